// File: doc/BRIEF.md
# Per-Channel Frame and Line Sequence Checker

This block sits behind a camera-link packet decoder. Each clock cycle it may receive one decoded packet event: a virtual channel number, a packet kind (frame start, frame end, line start, line end or payload), the 16-bit number field of sync packets, and a strobe that marks a payload with a bad checksum. For each of four virtual channels it keeps its own state: whether a frame is open, whether a line is open, the last frame number, the last line number, and whether a checksum fault has been seen in the current frame.

For every channel it raises single-cycle error pulses when frame or line boundaries do not pair up, or when frame or line numbers do not advance as expected. When a frame closes it also reports whether any payload in that frame had a checksum fault. Channels may interleave freely, because no channel's state depends on traffic on another channel. The pulses are meant to feed sticky status bits and an interrupt in a separate register block.

Top module: `vsg_seq_guard`

## Requirements
- R1: After reset, all error outputs are low and every channel is idle: no frame or line is open, and the stored frame and line numbers are zero. As a result, the first frame start on a channel raises no error.
- R2: A frame start (kind 0) on a channel whose frame is already open pulses that channel's bit of `err_frame_bound`. The channel then treats a new frame as open.
- R3: A frame end (kind 1) on a channel with no open frame pulses `err_frame_bound` for that channel. A frame end on an open frame closes the frame and also closes any open line without error.
- R4: A frame start pulses `err_frame_seq` when its number and the stored frame number are both non-zero and its number is not the stored number plus one. Numbering wraps from 0xFFFF to 1. Every frame start stores its number, including zero.
- R5: A frame start with number zero is never a sequence error. A non-zero frame start that follows a stored zero is also not a sequence error.
- R6: A line start (kind 2) while a line is open, or a line end (kind 3) while no line is open, pulses `err_line_bound` for that channel. After the pulse, the line state follows the packet: a line start leaves a line open and a line end leaves it closed.
- R7: A frame start resets the stored line number to zero. A line start with a non-zero number pulses `err_line_seq` unless that number equals the stored line number plus one, with 0xFFFF followed by 1. The first numbered line of a frame must therefore be 1. A non-zero line number is stored. A line start numbered zero is neither checked nor stored.
- R8: A frame end that closes an open frame pulses `err_frame_data` if at least one payload packet (kind 4) with `pkt_crc_err` high arrived on that channel while the frame was open. Checksum strobes that arrive outside an open frame, or with any other kind, are ignored.
- R9: Every error output has one bit per channel. Only the bit of the packet's channel can pulse, and packets on one channel never change the state of another channel.
- R10: Each error pulse appears in the cycle right after the cycle in which the packet is presented and lasts exactly one cycle.
- R11: Cycles with `pkt_valid` low, and packets of kind 5, 6 or 7, raise no error and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A packet event is present this cycle |
| pkt_vc | input | 2 | Virtual channel of the event |
| pkt_kind | input | 3 | 0 frame start, 1 frame end, 2 line start, 3 line end, 4 payload |
| pkt_num | input | 16 | Frame or line number carried by sync packets |
| pkt_crc_err | input | 1 | Payload checksum fault |
| err_frame_bound | output | 4 | Frame start/end pairing error, per channel |
| err_frame_seq | output | 4 | Frame number sequence error, per channel |
| err_line_bound | output | 4 | Line start/end pairing error, per channel |
| err_line_seq | output | 4 | Line number sequence error, per channel |
| err_frame_data | output | 4 | Closed frame contained a checksum fault, per channel |

## Verification
A frame boundary check and a frame numbering check can fire in the same cycle. This happens when a frame start arrives on a channel that already has an open frame and carries a number that breaks the sequence. The bench provokes this directly, with a duplicate frame start that has a skipped number, and also through random streams that mix repeated starts with corrupted numbers. In each case both pulses must appear together on the same channel bit, one cycle after the packet, and must match the expected values computed by the bench's reference model.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int NUM_W = 16;

  typedef enum logic [2:0] {
    K_FS   = 3'd0,
    K_FE   = 3'd1,
    K_LS   = 3'd2,
    K_LE   = 3'd3,
    K_DATA = 3'd4
  } pkt_kind_e;

  // successor of a sequence number: all-ones wraps to 1, zero is skipped
  function automatic logic [NUM_W-1:0] num_after(input logic [NUM_W-1:0] n);
    return (n == {NUM_W{1'b1}}) ? NUM_W'(1) : n + NUM_W'(1);
  endfunction
endpackage

// File: rtl/vsg_seqcmp.sv
module vsg_seqcmp
  import vsg_pkg::*;
#(
  parameter bit SKIP_ZERO_PREV = 1'b1
) (
  input  logic [NUM_W-1:0] prev,
  input  logic [NUM_W-1:0] cur,
  output logic             bad
);
  logic cur_used;
  logic prev_used;

  always_comb begin
    cur_used  = (cur != '0);
    prev_used = !(SKIP_ZERO_PREV && (prev == '0));
    bad       = cur_used && prev_used && (cur != num_after(prev));
  end
endmodule

// File: rtl/vsg_chan.sv
module vsg_chan
  import vsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [2:0]       kind,
  input  logic [NUM_W-1:0] num,
  input  logic             crc_err,
  output logic             err_fb,
  output logic             err_fs,
  output logic             err_lb,
  output logic             err_ls,
  output logic             err_fd
);
  logic             in_frame, in_line, crc_seen;
  logic [NUM_W-1:0] fnum, lnum;
  logic             ev_fs, ev_fe, ev_ls, ev_le, ev_bad_data;
  logic             f_bad, l_bad;

  assign ev_fs       = hit && (kind == K_FS);
  assign ev_fe       = hit && (kind == K_FE);
  assign ev_ls       = hit && (kind == K_LS);
  assign ev_le       = hit && (kind == K_LE);
  assign ev_bad_data = hit && (kind == K_DATA) && crc_err;

  vsg_seqcmp #(.SKIP_ZERO_PREV(1'b1)) u_fcmp (.prev(fnum), .cur(num), .bad(f_bad));
  vsg_seqcmp #(.SKIP_ZERO_PREV(1'b0)) u_lcmp (.prev(lnum), .cur(num), .bad(l_bad));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      in_line  <= 1'b0;
      crc_seen <= 1'b0;
      fnum     <= '0;
      lnum     <= '0;
      err_fb   <= 1'b0;
      err_fs   <= 1'b0;
      err_lb   <= 1'b0;
      err_ls   <= 1'b0;
      err_fd   <= 1'b0;
    end else begin
      err_fb <= (ev_fs && in_frame) || (ev_fe && !in_frame);
      err_fs <= ev_fs && f_bad;
      err_lb <= (ev_ls && in_line) || (ev_le && !in_line);
      err_ls <= ev_ls && l_bad;
      err_fd <= ev_fe && in_frame && crc_seen;
      if (ev_fs) begin
        in_frame <= 1'b1;
        in_line  <= 1'b0;
        crc_seen <= 1'b0;
        fnum     <= num;
        lnum     <= '0;
      end
      if (ev_fe) begin
        in_frame <= 1'b0;
        in_line  <= 1'b0;
        crc_seen <= 1'b0;
      end
      if (ev_ls) begin
        in_line <= 1'b1;
        if (num != '0) lnum <= num;
      end
      if (ev_le) in_line <= 1'b0;
      if (ev_bad_data && in_frame) crc_seen <= 1'b1;
    end
  end

  // R8
  fdata_at_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_fd |-> $past(ev_fe));
  // R3
  fdata_vs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_fd |-> !err_fb);
  // R4
  fseq_at_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_fs |-> $past(ev_fs));
  // R7
  lseq_at_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ls |-> $past(ev_ls));
  // R2
  fs_opens_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fs |=> in_frame);
endmodule

// File: rtl/vsg_seq_guard.sv
module vsg_seq_guard
  import vsg_pkg::*;
#(
  parameter int N_VC = 4,
  localparam int VC_W = (N_VC > 1) ? $clog2(N_VC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [VC_W-1:0]  pkt_vc,
  input  logic [2:0]       pkt_kind,
  input  logic [NUM_W-1:0] pkt_num,
  input  logic             pkt_crc_err,
  output logic [N_VC-1:0]  err_frame_bound,
  output logic [N_VC-1:0]  err_frame_seq,
  output logic [N_VC-1:0]  err_line_bound,
  output logic [N_VC-1:0]  err_line_seq,
  output logic [N_VC-1:0]  err_frame_data
);
  logic [N_VC-1:0] vc_hit;

  for (genvar g = 0; g < N_VC; g++) begin : g_chan
    assign vc_hit[g] = pkt_valid && (pkt_vc == VC_W'(g));
    vsg_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (vc_hit[g]),
      .kind    (pkt_kind),
      .num     (pkt_num),
      .crc_err (pkt_crc_err),
      .err_fb  (err_frame_bound[g]),
      .err_fs  (err_frame_seq[g]),
      .err_lb  (err_line_bound[g]),
      .err_ls  (err_line_seq[g]),
      .err_fd  (err_frame_data[g])
    );
  end

  // R9
  fbound_one_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_frame_bound));
  // R9
  lbound_one_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_line_bound));
  // R10
  idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> (err_frame_bound == '0) && (err_line_bound == '0) && (err_frame_seq == '0));
endmodule

// File: tb/test_vsg_seq_guard.sv
module test_vsg_seq_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [1:0]  pkt_vc = '0;
  logic [2:0]  pkt_kind = '0;
  logic [15:0] pkt_num = '0;
  logic        pkt_crc_err = 1'b0;
  logic [3:0]  err_frame_bound, err_frame_seq, err_line_bound, err_line_seq, err_frame_data;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic        m_inf [4];
  logic        m_inl [4];
  logic        m_crc [4];
  logic [15:0] m_fn  [4];
  logic [15:0] m_ln  [4];

  always #10 clk = ~clk;

  vsg_seq_guard i_vsg_seq_guard (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_vc(pkt_vc),
    .pkt_kind(pkt_kind), .pkt_num(pkt_num), .pkt_crc_err(pkt_crc_err),
    .err_frame_bound(err_frame_bound), .err_frame_seq(err_frame_seq),
    .err_line_bound(err_line_bound), .err_line_seq(err_line_seq),
    .err_frame_data(err_frame_data)
  );

  function automatic logic [15:0] succ(input logic [15:0] n);
    if (n == 16'd65535) return 16'd1;
    return n + 16'd1;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_inf[i] = 0; m_inl[i] = 0; m_crc[i] = 0; m_fn[i] = 0; m_ln[i] = 0;
    end
  endtask

  task automatic send(input logic [1:0] vc, input logic [2:0] kind,
                      input logic [15:0] num, input logic crc);
    logic [3:0] e_fb, e_fs, e_lb, e_ls, e_fd;
    e_fb = '0; e_fs = '0; e_lb = '0; e_ls = '0; e_fd = '0;
    case (kind)
      3'd0: begin
        e_fb[vc] = m_inf[vc];
        e_fs[vc] = (num != 0) && (m_fn[vc] != 0) && (num != succ(m_fn[vc]));
        m_inf[vc] = 1; m_inl[vc] = 0; m_crc[vc] = 0; m_fn[vc] = num; m_ln[vc] = 0;
      end
      3'd1: begin
        e_fb[vc] = !m_inf[vc];
        e_fd[vc] = m_inf[vc] && m_crc[vc];
        m_inf[vc] = 0; m_inl[vc] = 0; m_crc[vc] = 0;
      end
      3'd2: begin
        e_lb[vc] = m_inl[vc];
        e_ls[vc] = (num != 0) && (num != succ(m_ln[vc]));
        m_inl[vc] = 1;
        if (num != 0) m_ln[vc] = num;
      end
      3'd3: begin
        e_lb[vc] = !m_inl[vc];
        m_inl[vc] = 0;
      end
      3'd4: if (crc && m_inf[vc]) m_crc[vc] = 1;
      default: ;
    endcase
    @(negedge clk);
    pkt_valid = 1; pkt_vc = vc; pkt_kind = kind; pkt_num = num; pkt_crc_err = crc;
    @(posedge clk); #1;
    chk("R2 R3 R9 frame boundary", err_frame_bound, e_fb);
    chk("R4 R5 frame sequence", err_frame_seq, e_fs);
    chk("R6 line boundary", err_line_bound, e_lb);
    chk("R7 line sequence", err_line_seq, e_ls);
    chk("R8 R11 frame data", err_frame_data, e_fd);
    @(negedge clk);
    pkt_valid = 0; pkt_crc_err = $urandom_range(0, 1);
    @(posedge clk); #1;
    chk("R10 R11 pulse ends", err_frame_bound | err_frame_seq | err_line_bound
        | err_line_seq | err_frame_data, 4'b0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset fbound", err_frame_bound, 4'b0);
    chk("R1 reset fdata", err_frame_data | err_line_seq, 4'b0);
    @(negedge clk); rst_n = 1;
    // R1 first frame start, arbitrary number, no error
    send(0, 0, 16'd5, 0);
    // R2 R4 collision: duplicate start with a skipped number
    send(0, 0, 16'd7, 0);
    // R3 frame end twice
    send(0, 1, 0, 0);
    send(0, 1, 0, 0);
    // R4 wrap from 0xFFFF to 1
    send(1, 0, 16'hFFFF, 0); send(1, 1, 0, 0); send(1, 0, 16'd1, 0); send(1, 1, 0, 0);
    // R5 zero numbering
    send(2, 0, 16'd0, 0); send(2, 1, 0, 0); send(2, 0, 16'd9, 0);
    // R7 lines, R6 boundaries, interleaved with vc 3 (R9)
    send(2, 2, 16'd1, 0); send(3, 0, 16'd4, 0); send(2, 3, 0, 0);
    send(2, 2, 16'd2, 0); send(2, 3, 0, 0); send(2, 2, 16'd4, 0);
    send(2, 2, 16'd0, 0); send(2, 3, 0, 0); send(2, 3, 0, 0);
    // R8 checksum inside frame, R11 ignored kinds and strobes
    send(3, 4, 0, 0); send(3, 6, 0, 1); send(3, 0, 16'd0, 1); send(3, 4, 0, 1);
    send(3, 7, 16'd3, 0); send(3, 1, 0, 0); send(3, 1, 0, 0);
    // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  v;
      logic [2:0]  k;
      logic [15:0] n;
      int r;
      v = 2'($urandom_range(0, 3));
      r = $urandom_range(0, 9);
      k = (r == 0) ? 3'd0 : (r == 1) ? 3'd1 : (r < 4) ? 3'd2 : (r < 6) ? 3'd3 :
          (r < 9) ? 3'd4 : 3'($urandom_range(5, 7));
      r = $urandom_range(0, 9);
      if (k == 3'd0) n = (r < 7) ? succ(m_fn[v]) : (r == 7) ? 16'd0 : 16'($urandom);
      else if (k == 3'd2) n = (r < 7) ? succ(m_ln[v]) : (r == 7) ? 16'd0 : 16'($urandom_range(0, 8));
      else n = 16'($urandom);
      send(v, k, n, 1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule